// File: doc/BRIEF.md
# Multi-Domain Power Sequencer

This block is the controller side of four power-state request channels. The four channels serve the logic domain, the snoop filter, the lower half of the cache RAM and the upper half of the cache RAM. Each channel uses a four-phase handshake. The controller places a target state on the channel's state bus, raises the request, waits for the device to accept or deny, drops the request, and waits for the response to clear. Software selects a whole-system power mode with a one-cycle command. The sequencer then works out which channels must change and runs their handshakes one at a time.

The order of the channel handshakes is fixed.
- When the logic domain wakes from a shutdown mode, the logic channel goes first.
- When the logic domain goes down, the logic channel goes last.
- When the snoop filter is to end up fully on, the memory channels run upper half, lower half, filter. Otherwise they run filter, lower half, upper half.
- Successive request assertions are kept at least `MIN_GAP` cycles apart, so a receiver with a long path still sees them in issue order.

If a channel denies, the sequencer returns every channel it has already moved to the mode that was in force before the command. It then reports completion.

Top module: `pwr_seq`

## Requirements
- R1: While reset is held and on its release, every request is low, `busy`, `done` and `cmd_err` are low, and the state buses show the `RESET_MODE` configuration (all ON by default).
- R2: Channel i uses state bits `pc_state[2i+1:2i]`, with OFF=0, RET=1 and ON=2. Channel 0 is logic, 1 is snoop filter, 2 is lower RAM half and 3 is upper RAM half. Mode codes are given as logic/filter/lower/upper:
  - 0 = OFF/OFF/OFF/OFF
  - 1 = ON/OFF/OFF/OFF
  - 2 = ON/ON/OFF/OFF
  - 3 = ON/ON/ON/OFF
  - 4 = ON/ON/ON/ON
  - 5 = OFF/RET/OFF/OFF
  - 6 = OFF/RET/RET/OFF
  - 7 = OFF/RET/RET/RET

  After an accepted command, every state bus holds the selected mode's value.
- R3: When the logic channel goes from OFF to ON, its handshake completes before any other channel raises its request.
- R4: When the logic channel goes from ON to OFF, its request is raised only after every other changing channel has been accepted.
- R5: At most one request is high at a time, and two request rising edges are at least `MIN_GAP` (15) cycles apart.
- R6: If the target filter state is ON, the memory channels are handled as upper, lower, filter. Otherwise they are handled as filter, lower, upper.
- R7: A channel whose state already matches the target is never requested. A command for the current mode completes with no request at all.
- R8: After a deny, every channel that moved is returned to its state from before the command. The same ordering rules apply, and the denying channel's bus reverts to its held state.
- R9: A command with a code of 8 or more raises a sticky `cmd_err`, starts nothing and leaves every channel untouched.
- R10: `done` is a single-cycle pulse. It is raised after the final handshake of a command, including any rollback, has fully closed, with every request and response low.
- R11: A command presented while `busy` is high is ignored.
- R12: A state bus changes only while its request and both responses are low. A request rises only while both responses are low. A request falls only after exactly one response is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_mode | input | 4 | Requested system mode code |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Sticky flag for an unsupported mode code |
| pc_req | output | 4 | Per-channel request |
| pc_state | output | 8 | Per-channel requested state, 2 bits per channel |
| pc_accept | input | 4 | Per-channel accept response |
| pc_deny | input | 4 | Per-channel deny response |

## Verification
The bound checker watches the handshake rules on every cycle:
- the state buses stay stable outside idle phases;
- requests rise and fall only under the permitted response conditions;
- only one request is high at a time, and request rising edges keep the minimum spacing;
- `done` is a clean single-cycle pulse, and `cmd_err` never falls.

The channel order cannot be expressed as a single-cycle property, so only the bench's scoreboard can show it. This covers logic first on wake-up, logic last on shutdown, the memory order in each direction, skipped unchanged channels and the rollback sequence after a deny. The same holds for rejected and ignored commands.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_CH    = 4;
  localparam int SW        = 2;
  localparam int MW        = 4;
  localparam int CW        = $clog2(NUM_CH);
  localparam int NUM_MODES = 8;

  localparam logic [SW-1:0] ST_OFF = 2'd0;
  localparam logic [SW-1:0] ST_RET = 2'd1;
  localparam logic [SW-1:0] ST_ON  = 2'd2;

  localparam int CH_LOGIC = 0;
  localparam int CH_FILT  = 1;
  localparam int CH_RLO   = 2;
  localparam int CH_RHI   = 3;

  localparam logic [MW-1:0] MD_OFF      = 4'd0;
  localparam logic [MW-1:0] MD_NOCACHE  = 4'd1;
  localparam logic [MW-1:0] MD_FILT     = 4'd2;
  localparam logic [MW-1:0] MD_HALF     = 4'd3;
  localparam logic [MW-1:0] MD_FULL     = 4'd4;
  localparam logic [MW-1:0] MD_FILT_RET = 4'd5;
  localparam logic [MW-1:0] MD_HALF_RET = 4'd6;
  localparam logic [MW-1:0] MD_FULL_RET = 4'd7;

  typedef logic [NUM_CH*SW-1:0] pvec_t;

  typedef enum logic [1:0] {CH_IDLE, CH_SETUP, CH_ASK, CH_REL} chfsm_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PICK, SQ_WAIT} sqfsm_e;

  function automatic pvec_t pack4(input logic [SW-1:0] lg, input logic [SW-1:0] fl,
                                  input logic [SW-1:0] lo, input logic [SW-1:0] hi);
    return {hi, lo, fl, lg};
  endfunction

  // Per-channel states of each system mode
  function automatic pvec_t mode_vec(input logic [MW-1:0] m);
    pvec_t v;
    case (m)
      MD_NOCACHE:  v = pack4(ST_ON,  ST_OFF, ST_OFF, ST_OFF);
      MD_FILT:     v = pack4(ST_ON,  ST_ON,  ST_OFF, ST_OFF);
      MD_HALF:     v = pack4(ST_ON,  ST_ON,  ST_ON,  ST_OFF);
      MD_FULL:     v = pack4(ST_ON,  ST_ON,  ST_ON,  ST_ON);
      MD_FILT_RET: v = pack4(ST_OFF, ST_RET, ST_OFF, ST_OFF);
      MD_HALF_RET: v = pack4(ST_OFF, ST_RET, ST_RET, ST_OFF);
      MD_FULL_RET: v = pack4(ST_OFF, ST_RET, ST_RET, ST_RET);
      default:     v = pack4(ST_OFF, ST_OFF, ST_OFF, ST_OFF);
    endcase
    return v;
  endfunction

  function automatic logic mode_ok(input logic [MW-1:0] m);
    return m < MW'(NUM_MODES);
  endfunction

endpackage

// File: rtl/pwr_seq_order.sv
module pwr_seq_order
  import pwr_seq_pkg::*;
(
  input  logic                 from_logic_on,
  input  pvec_t                tgt,
  output logic [NUM_CH*CW-1:0] order
);

  logic            up;
  logic            lfirst;
  logic [CW-1:0]   mem [NUM_CH-1];

  always_comb begin
    up     = (tgt[CH_FILT*SW +: SW] == ST_ON);
    lfirst = !from_logic_on && (tgt[CH_LOGIC*SW +: SW] == ST_ON);
    mem[0] = up ? CW'(CH_RHI) : CW'(CH_FILT);
    mem[1] = CW'(CH_RLO);
    mem[2] = up ? CW'(CH_FILT) : CW'(CH_RHI);
    order  = '0;
    for (int k = 0; k < NUM_CH - 1; k++) begin
      order[(k + (lfirst ? 1 : 0))*CW +: CW] = mem[k];
    end
    order[(lfirst ? 0 : NUM_CH - 1)*CW +: CW] = CW'(CH_LOGIC);
  end

endmodule

// File: rtl/pwr_seq_gap.sv
module pwr_seq_gap #(
  parameter int MIN_GAP = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ok
);

  localparam int            CNW = $clog2(MIN_GAP + 1);
  localparam logic [CNW-1:0] LIM = CNW'(MIN_GAP - 1);

  logic [CNW-1:0] cnt_q, cnt_d;

  assign ok = (cnt_q >= LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = '0;
    else if (!ok)   cnt_d = cnt_q + CNW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIM;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_seq_chan.sv
module pwr_seq_chan
  import pwr_seq_pkg::*;
#(
  parameter logic [SW-1:0] RST_ST = ST_ON
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] tgt,
  input  logic          acc,
  input  logic          den,
  output logic          req,
  output logic [SW-1:0] st,
  output logic [SW-1:0] cur,
  output logic          fin,
  output logic          fin_deny
);

  chfsm_e        fsm_q, fsm_d;
  logic          req_q, req_d;
  logic [SW-1:0] bus_q, bus_d;
  logic [SW-1:0] cur_q, cur_d;
  logic          dn_q, dn_d;
  logic          fin_q, fin_d;
  logic          fdn_q, fdn_d;

  assign req      = req_q;
  assign st       = bus_q;
  assign cur      = cur_q;
  assign fin      = fin_q;
  assign fin_deny = fdn_q;

  always_comb begin
    fsm_d = fsm_q;
    req_d = req_q;
    bus_d = bus_q;
    cur_d = cur_q;
    dn_d  = dn_q;
    fin_d = 1'b0;
    fdn_d = 1'b0;
    case (fsm_q)
      CH_IDLE: if (start) begin
        bus_d = tgt;
        fsm_d = CH_SETUP;
      end
      CH_SETUP: begin
        req_d = 1'b1;
        fsm_d = CH_ASK;
      end
      CH_ASK: begin
        if (acc) begin
          req_d = 1'b0;
          dn_d  = 1'b0;
          cur_d = bus_q;
          fsm_d = CH_REL;
        end else if (den) begin
          req_d = 1'b0;
          dn_d  = 1'b1;
          fsm_d = CH_REL;
        end
      end
      CH_REL: if (!acc && !den) begin
        fin_d = 1'b1;
        fdn_d = dn_q;
        if (dn_q) bus_d = cur_q;
        fsm_d = CH_IDLE;
      end
      default: fsm_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q <= CH_IDLE;
      req_q <= 1'b0;
      bus_q <= RST_ST;
      cur_q <= RST_ST;
      dn_q  <= 1'b0;
      fin_q <= 1'b0;
      fdn_q <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      req_q <= req_d;
      bus_q <= bus_d;
      cur_q <= cur_d;
      dn_q  <= dn_d;
      fin_q <= fin_d;
      fdn_q <= fdn_d;
    end
  end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int            MIN_GAP    = 15,
  parameter logic [MW-1:0] RESET_MODE = MD_FULL
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [MW-1:0]        cmd_mode,
  output logic                 busy,
  output logic                 done,
  output logic                 cmd_err,
  output logic [NUM_CH-1:0]    pc_req,
  output logic [NUM_CH*SW-1:0] pc_state,
  input  logic [NUM_CH-1:0]    pc_accept,
  input  logic [NUM_CH-1:0]    pc_deny
);

  localparam pvec_t          RST_VEC = mode_vec(RESET_MODE);
  localparam int             PW      = CW + 1;
  localparam logic [PW-1:0]  PTR_END = PW'(NUM_CH);

  sqfsm_e                sq_q, sq_d;
  logic [PW-1:0]         ptr_q, ptr_d;
  logic [MW-1:0]         tgt_q, tgt_d;
  logic [MW-1:0]         mode_q, mode_d;
  logic                  roll_q, roll_d;
  logic [NUM_CH*CW-1:0]  ord_q, ord_d, ord_new;
  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic [CW-1:0]         ch_q, ch_d;

  pvec_t                 cur_vec, tgt_vec, ord_tgt;
  logic [NUM_CH-1:0]     start_v, fin_v, fdn_v;
  logic                  gap_ok, go, logic_on;
  logic [CW-1:0]         sel;
  logic [MW-1:0]         ord_mode;

  assign tgt_vec  = mode_vec(tgt_q);
  assign ord_mode = (sq_q == SQ_IDLE) ? cmd_mode : mode_q;
  assign ord_tgt  = mode_vec(ord_mode);
  assign logic_on = (cur_vec[CH_LOGIC*SW +: SW] == ST_ON);
  assign sel      = ord_q[ptr_q[CW-1:0]*CW +: CW];
  assign start_v  = go ? (NUM_CH'(1) << sel) : '0;

  assign busy    = (sq_q != SQ_IDLE);
  assign done    = done_q;
  assign cmd_err = err_q;

  pwr_seq_order u_order (
    .from_logic_on (logic_on),
    .tgt           (ord_tgt),
    .order         (ord_new)
  );

  pwr_seq_gap #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .ok    (gap_ok)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwr_seq_chan #(.RST_ST(RST_VEC[g*SW +: SW])) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_v[g]),
      .tgt      (tgt_vec[g*SW +: SW]),
      .acc      (pc_accept[g]),
      .den      (pc_deny[g]),
      .req      (pc_req[g]),
      .st       (pc_state[g*SW +: SW]),
      .cur      (cur_vec[g*SW +: SW]),
      .fin      (fin_v[g]),
      .fin_deny (fdn_v[g])
    );
  end

  always_comb begin
    sq_d   = sq_q;
    ptr_d  = ptr_q;
    tgt_d  = tgt_q;
    mode_d = mode_q;
    roll_d = roll_q;
    ord_d  = ord_q;
    err_d  = err_q;
    ch_d   = ch_q;
    done_d = 1'b0;
    go     = 1'b0;
    case (sq_q)
      SQ_IDLE: if (cmd_valid) begin
        if (!mode_ok(cmd_mode)) begin
          err_d = 1'b1;
        end else begin
          tgt_d  = cmd_mode;
          roll_d = 1'b0;
          ptr_d  = '0;
          ord_d  = ord_new;
          sq_d   = SQ_PICK;
        end
      end
      SQ_PICK: begin
        if (ptr_q == PTR_END) begin
          done_d = 1'b1;
          mode_d = tgt_q;
          sq_d   = SQ_IDLE;
        end else if (tgt_vec[sel*SW +: SW] == cur_vec[sel*SW +: SW]) begin
          ptr_d = ptr_q + PW'(1);
        end else if (gap_ok) begin
          go    = 1'b1;
          ch_d  = sel;
          ptr_d = ptr_q + PW'(1);
          sq_d  = SQ_WAIT;
        end
      end
      SQ_WAIT: if (fin_v[ch_q]) begin
        if (fdn_v[ch_q] && !roll_q) begin
          tgt_d  = mode_q;
          roll_d = 1'b1;
          ptr_d  = '0;
          ord_d  = ord_new;
        end
        sq_d = SQ_PICK;
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      ptr_q  <= '0;
      tgt_q  <= RESET_MODE;
      mode_q <= RESET_MODE;
      roll_q <= 1'b0;
      ord_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ch_q   <= '0;
    end else begin
      sq_q   <= sq_d;
      ptr_q  <= ptr_d;
      tgt_q  <= tgt_d;
      mode_q <= mode_d;
      roll_q <= roll_d;
      ord_q  <= ord_d;
      done_q <= done_d;
      err_q  <= err_d;
      ch_q   <= ch_d;
    end
  end

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int MIN_GAP = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [MW-1:0]        cmd_mode,
  input logic                 busy,
  input logic                 done,
  input logic                 cmd_err,
  input logic [NUM_CH-1:0]    pc_req,
  input logic [NUM_CH*SW-1:0] pc_state,
  input logic [NUM_CH-1:0]    pc_accept,
  input logic [NUM_CH-1:0]    pc_deny
);

  localparam int GW = $clog2(MIN_GAP + 1);

  logic [NUM_CH-1:0] rq_q;
  logic [GW-1:0]     gcnt;
  logic              rise;

  assign rise = |(pc_req & ~rq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_q <= '0;
      gcnt <= GW'(MIN_GAP);
    end else begin
      rq_q <= pc_req;
      if (rise)                   gcnt <= GW'(1);
      else if (gcnt < GW'(MIN_GAP)) gcnt <= gcnt + GW'(1);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assert_state_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_state[i*SW +: SW] != $past(pc_state[i*SW +: SW])) |->
        ($past(!pc_req[i] && !pc_accept[i] && !pc_deny[i]) && !pc_req[i]));

    assert_req_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pc_req[i]) |-> $past(!pc_accept[i] && !pc_deny[i]));

    assert_req_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pc_req[i]) |-> $past(pc_accept[i] ^ pc_deny[i]));
  end

  assert_one_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pc_req));

  assert_req_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (gcnt >= GW'(MIN_GAP)));

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_req == '0 && pc_accept == '0 && pc_deny == '0 && !busy));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

endmodule

bind pwr_seq pwr_seq_chk #(.MIN_GAP(MIN_GAP)) u_chk (.*);

// File: tb/pwr_seq_tb.sv
`timescale 1ns/1ps
module pwr_seq_tb;
  import pwr_seq_pkg::*;

  typedef struct {
    int    ch;
    int    st;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_mode;
  logic        busy, done, cmd_err;
  logic [3:0]  pc_req, pc_accept, pc_deny;
  logic [7:0]  pc_state;
  logic [3:0]  deny_en;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  int last_rise = -1000;
  bit ended  = 0;
  item_t q[$];

  always #4 clk = ~clk;

  pwr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .busy(busy), .done(done), .cmd_err(cmd_err),
    .pc_req(pc_req), .pc_state(pc_state), .pc_accept(pc_accept), .pc_deny(pc_deny)
  );

  // Device models: respond two cycles after a request, release after it drops
  for (genvar g = 0; g < 4; g++) begin : g_dev
    logic a_r, d_r;
    assign pc_accept[g] = a_r;
    assign pc_deny[g]   = d_r;
    initial begin
      a_r = 1'b0;
      d_r = 1'b0;
      forever begin
        @(negedge clk);
        if (pc_req[g]) begin
          repeat (2) @(posedge clk);
          #1;
          if (deny_en[g]) d_r = 1'b1;
          else            a_r = 1'b1;
          do @(negedge clk); while (pc_req[g]);
          @(posedge clk);
          #1 a_r = 1'b0; d_r = 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic expect_req(input int ch, input int st, input string tag);
    item_t it;
    it.ch = ch; it.st = st; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Monitor: scoreboard pop on every request rise, spacing and done shape
  logic [3:0] req_prev = '0;
  logic       done_prev = 1'b0;
  always @(negedge clk) begin
    item_t it;
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (pc_req[i] && !req_prev[i]) begin
          if (q.size() == 0) begin
            chk(0, "R7 unexpected request channel", i, -1);
          end else begin
            it = q.pop_front();
            chk(it.ch == i && int'(pc_state[2*i +: 2]) == it.st,
                {it.tag, " request order/state (ch*4+state)"},
                i*4 + int'(pc_state[2*i +: 2]), it.ch*4 + it.st);
          end
          chk(cyc - last_rise >= 15, "R5 request spacing", cyc - last_rise, 15);
          last_rise = cyc;
        end
      end
      if (done) begin
        chk(!done_prev, "R10 done width", 2, 1);
        chk(pc_req == 4'd0 && pc_accept == 4'd0, "R10 done after close",
            int'(pc_req), 0);
      end
    end
    req_prev  = pc_req;
    done_prev = done;
  end

  task automatic run_cmd(input logic [3:0] m, input logic [7:0] fin_exp,
                         input int inject, input string tag);
    int n;
    bit seen;
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_mode = m;
    @(posedge clk); #1 cmd_valid = 1'b0;
    seen = 0;
    n = 0;
    while (!seen && n < 3000) begin
      @(negedge clk);
      n++;
      if (done) seen = 1;
      if (n == inject) begin
        chk(busy, "R11 busy during sequence", busy, 1);
        #2 cmd_valid = 1'b1; cmd_mode = MD_OFF;
        @(posedge clk); #1 cmd_valid = 1'b0;
      end
    end
    chk(seen, {tag, " R10 done pulse seen"}, seen, 1);
    chk(q.size() == 0, {tag, " all expected requests issued"}, q.size(), 0);
    chk(pc_state == fin_exp, {tag, " R2 final channel states"}, pc_state, fin_exp);
    chk(!busy, {tag, " idle after done"}, busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int seen_req;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = '0; deny_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc_req == 4'd0, "R1 requests low in reset", pc_req, 0);
    chk(pc_state == 8'hAA, "R1 reset states all ON", pc_state, 8'hAA);
    chk(!busy && !done && !cmd_err, "R1 flags low in reset", {busy, done, cmd_err}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(pc_req == 4'd0 && pc_state == 8'hAA, "R1 state after release", pc_state, 8'hAA);

    // R9: unsupported mode code
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_mode = 4'd9;
    @(posedge clk); #1 cmd_valid = 1'b0;
    seen_req = 0;
    repeat (40) begin
      @(negedge clk);
      if (pc_req != 4'd0 || busy) seen_req++;
    end
    chk(seen_req == 0, "R9 no channel touched", seen_req, 0);
    chk(cmd_err, "R9 error flag set", cmd_err, 1);
    chk(pc_state == 8'hAA, "R9 states unchanged", pc_state, 8'hAA);

    // R4/R6: full to half retention, filter first, logic last
    expect_req(CH_FILT, 1, "R6");
    expect_req(CH_RLO,  1, "R6");
    expect_req(CH_RHI,  0, "R6");
    expect_req(CH_LOGIC, 0, "R4");
    run_cmd(MD_HALF_RET, 8'h14, -1, "shutdown");

    // R3/R6: wake to full, logic first then upper, lower, filter
    expect_req(CH_LOGIC, 2, "R3");
    expect_req(CH_RHI,  2, "R6");
    expect_req(CH_RLO,  2, "R6");
    expect_req(CH_FILT, 2, "R6");
    run_cmd(MD_FULL, 8'hAA, -1, "wake");

    // R7: no-cache mode, logic unchanged and skipped
    expect_req(CH_FILT, 0, "R7");
    expect_req(CH_RLO,  0, "R7");
    expect_req(CH_RHI,  0, "R7");
    run_cmd(MD_NOCACHE, 8'h02, -1, "nocache");

    // R6/R11: back to full with a command injected while busy
    expect_req(CH_RHI,  2, "R6");
    expect_req(CH_RLO,  2, "R6");
    expect_req(CH_FILT, 2, "R11");
    run_cmd(MD_FULL, 8'hAA, 20, "busy-ignore");
    repeat (40) @(negedge clk);
    chk(pc_state == 8'hAA && !busy, "R11 injected command had no effect", pc_state, 8'hAA);

    // R7: same mode again, no request at all
    run_cmd(MD_FULL, 8'hAA, -1, "same-mode");

    // R8: logic denies the shutdown, memory channels rolled back
    deny_en = 4'b0001;
    expect_req(CH_FILT, 1, "R8");
    expect_req(CH_RLO,  0, "R8");
    expect_req(CH_RHI,  0, "R8");
    expect_req(CH_LOGIC, 0, "R8");
    expect_req(CH_RHI,  2, "R8");
    expect_req(CH_RLO,  2, "R8");
    expect_req(CH_FILT, 2, "R8");
    run_cmd(MD_FILT_RET, 8'hAA, -1, "deny");
    deny_en = '0;

    // R2: full retention mode
    expect_req(CH_FILT, 1, "R2");
    expect_req(CH_RLO,  1, "R2");
    expect_req(CH_RHI,  1, "R2");
    expect_req(CH_LOGIC, 0, "R4");
    run_cmd(MD_FULL_RET, 8'h54, -1, "full-ret");

    chk(cmd_err, "R9 error flag still set", cmd_err, 1);
    finish_run();
  end

endmodule